// File: doc/BRIEF.md
# Timestamped Host Write Queue with Slot-Paced Drain

This block sits between a host data port and the three internal memories of a video controller: a byte-wide video RAM, a 16-bit colour RAM and a small 16-bit vertical-scroll RAM. Each accepted host write becomes a queue entry. The entry captures the current target address, the 16-bit value, the command code in force at that moment and a ready time. The ready time lies three access slots after the write. A slot is 16 master clocks in wide mode and 20 in narrow mode.

The surrounding controller pulses a slot strobe once per external access slot and supplies the running master-clock count. On each strobe the queue makes at most one memory write. It writes only when the head entry's ready time has been reached. If no entry is ready, it raises a flag that tells other logic the slot went unused. A video RAM entry needs two slots, one per byte. A full queue stalls the host. The block also keeps the current target address, which software loads and which advances by a programmable step after every accepted write.

Top module: `slotWriteQueue`

## Requirements
- R1: After reset the queue is empty, all three write enables are low, `slotUnused` is low and `hostStall` is low.
- R2: An entry is written only on a slot strobe where `cycleNow` is at least its enqueue `cycleNow` plus 48 (wideMode=1) or plus 60 (wideMode=0). The mode is sampled at enqueue.
- R3: At most one memory write takes place per slot. Each write enable is a single-clock pulse in the clock after the slot-strobe edge that decided it, and no write occurs without a slot strobe.
- R4: On every slot strobe, `slotUnused` is cleared and then set again when the queue is empty or the head entry is not yet ready. It holds its value between strobes.
- R5: For code 1 (low four bits of `cmdCode`), the first eligible slot writes `hostData[15:8]` at the entry address and the entry stays at the head. The next eligible slot writes `hostData[7:0]` at the address with bit 0 inverted and removes the entry.
- R6: For code 3, one slot writes the full 16-bit value to colour RAM index address[6:1] and removes the entry.
- R7: For code 5, the scroll index is address[6:1]. The value is written when the index is below 40, and dropped when it is 40 or more. The entry is removed in both cases.
- R8: A host write whose `cmdCode` bit 0 is 0 is a read setup. It queues nothing and leaves the current address unchanged.
- R9: With 4 entries queued, a host write with `cmdCode` bit 0 set raises `hostStall` in the same cycle and is not taken. It is taken once an entry has drained.
- R10: Each accepted write stores the current address and then adds `autoInc` to it. `addrLoad` replaces the current address after any same-cycle advance.
- R11: Entries drain strictly in the order they were accepted.
- R12: An entry whose code is none of 1, 3 or 5 (for example 9) is removed in one slot without any memory write, and that slot is not reported as unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host data write request |
| hostData | input | 16 | Host write value |
| cmdCode | input | 4 | Active command code; bit 0 marks a write setup, the value selects the memory |
| addrLoad | input | 1 | Load the current target address |
| addrLoadVal | input | 16 | Address value to load |
| autoInc | input | 8 | Address step added after each accepted write |
| hostStall | output | 1 | Write request refused because the queue is full |
| slotStrobe | input | 1 | One pulse per external access slot |
| cycleNow | input | 32 | Running master-clock count |
| wideMode | input | 1 | 1: 16-clock slots, 0: 20-clock slots |
| vramWe | output | 1 | Video RAM byte write enable |
| vramAddr | output | 16 | Video RAM byte address |
| vramData | output | 8 | Video RAM byte value |
| cramWe | output | 1 | Colour RAM write enable |
| cramAddr | output | 6 | Colour RAM word index |
| cramData | output | 16 | Colour RAM value |
| scrollWe | output | 1 | Scroll RAM write enable |
| scrollAddr | output | 6 | Scroll RAM word index |
| scrollData | output | 16 | Scroll RAM value |
| slotUnused | output | 1 | Last slot performed no drain |

## Verification
A single video RAM write in wide mode, followed by a long idle stretch, separates the correct ready time from one off by a slot. It also exposes the two-slot byte split and the inverted low address bit. A read-setup write followed by a colour write shows whether the ignored request advanced the address. Bursts that fill the queue, mixed with unknown codes and scroll indices on both sides of 40, test the stall, the ordering, the silent drops and the unused flag. Narrow mode is run as well to confirm the longer latency. A long seeded random run then mixes modes, address loads, step sizes and all codes, and compares every cycle against a queue model kept in the bench.

// File: rtl/swq_pkg.sv
package swq_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] DEST_VRAM   = 4'd1;
  localparam logic [CODE_W-1:0] DEST_CRAM   = 4'd3;
  localparam logic [CODE_W-1:0] DEST_SCROLL = 4'd5;

  typedef struct packed {
    logic push;
    logic pop;
    logic markPartial;
    logic writeHi;
    logic writeLo;
    logic writeCram;
    logic writeScroll;
  } swq_strobe_t;
endpackage

// File: rtl/swq_ctrl.sv
module swq_ctrl
  import swq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CYC_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              slotStrobe,
  input  logic [CYC_W-1:0]  cycleNow,
  input  logic [CYC_W-1:0]  headReady,
  input  logic [CODE_W-1:0] headCode,
  input  logic              headPartial,
  output logic              hostStall,
  output logic              slotUnused,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output swq_strobe_t       strb
);
  logic [CNT_W-1:0] count;
  logic full, headValid, headDue, drain;
  logic isVram, isCram, isScroll;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    full      = (count == CNT_W'(DEPTH));
    headValid = (count != '0);
    headDue   = headValid && (cycleNow >= headReady);
    drain     = slotStrobe && headDue;
    isVram    = (headCode == DEST_VRAM);
    isCram    = (headCode == DEST_CRAM);
    isScroll  = (headCode == DEST_SCROLL);
    hostStall = hostReq && full;

    strb             = '0;
    strb.push        = hostReq && !full;
    strb.writeHi     = drain && isVram && !headPartial;
    strb.markPartial = drain && isVram && !headPartial;
    strb.writeLo     = drain && isVram && headPartial;
    strb.writeCram   = drain && isCram;
    strb.writeScroll = drain && isScroll;
    strb.pop         = drain && !(isVram && !headPartial);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      headPtr    <= '0;
      tailPtr    <= '0;
      slotUnused <= 1'b0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.push) tailPtr <= nextPtr(tailPtr);
      if (strb.pop)  headPtr <= nextPtr(headPtr);
      if (slotStrobe) slotUnused <= !headDue;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R9
  AST_STALL_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (hostStall && !strb.pop) |=> (count == CNT_W'(DEPTH))); // R9
  AST_EMPTY_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && count == '0) |=> slotUnused); // R4
endmodule

// File: rtl/swq_data.sv
module swq_data
  import swq_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int CYC_W        = 32,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int INC_W        = 8,
  parameter int CRAM_AW      = 6,
  parameter int SCROLL_AW    = 6,
  parameter int SCROLL_WORDS = 40,
  parameter int SLOT_WIDE    = 16,
  parameter int SLOT_NARROW  = 20,
  parameter int LAT_SLOTS    = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BYTE_W = DATA_W / 2,
  localparam int READY_WIDE = SLOT_WIDE * LAT_SLOTS,
  localparam int READY_NARROW = SLOT_NARROW * LAT_SLOTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swq_strobe_t          strb,
  input  logic [PTR_W-1:0]     headPtr,
  input  logic [PTR_W-1:0]     tailPtr,
  input  logic [DATA_W-1:0]    hostData,
  input  logic [CODE_W-1:0]    cmdCode,
  input  logic                 addrLoad,
  input  logic [ADDR_W-1:0]    addrLoadVal,
  input  logic [INC_W-1:0]     autoInc,
  input  logic [CYC_W-1:0]     cycleNow,
  input  logic                 wideMode,
  output logic [CYC_W-1:0]     headReady,
  output logic [CODE_W-1:0]    headCode,
  output logic                 headPartial,
  output logic [ADDR_W-1:0]    curAddr,
  output logic                 vramWe,
  output logic [ADDR_W-1:0]    vramAddr,
  output logic [BYTE_W-1:0]    vramData,
  output logic                 cramWe,
  output logic [CRAM_AW-1:0]   cramAddr,
  output logic [DATA_W-1:0]    cramData,
  output logic                 scrollWe,
  output logic [SCROLL_AW-1:0] scrollAddr,
  output logic [DATA_W-1:0]    scrollData
);
  localparam logic [SCROLL_AW:0] SCROLL_LIM = (SCROLL_AW + 1)'(SCROLL_WORDS);

  logic [ADDR_W-1:0] addrQ  [DEPTH];
  logic [DATA_W-1:0] valQ   [DEPTH];
  logic [CODE_W-1:0] codeQ  [DEPTH];
  logic [CYC_W-1:0]  readyQ [DEPTH];
  logic              partQ  [DEPTH];

  logic [ADDR_W-1:0]    headAddr;
  logic [DATA_W-1:0]    headVal;
  logic [SCROLL_AW-1:0] scrollIdx;
  logic                 scrollInRange;
  logic [CYC_W-1:0]     readyAt;

  always_comb begin
    headAddr      = addrQ[headPtr];
    headVal       = valQ[headPtr];
    headCode      = codeQ[headPtr];
    headReady     = readyQ[headPtr];
    headPartial   = partQ[headPtr];
    scrollIdx     = headAddr[SCROLL_AW:1];
    scrollInRange = ({1'b0, scrollIdx} < SCROLL_LIM);
    readyAt       = cycleNow + (wideMode ? CYC_W'(READY_WIDE) : CYC_W'(READY_NARROW));
  end

  // entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        addrQ[i]  <= '0;
        valQ[i]   <= '0;
        codeQ[i]  <= '0;
        readyQ[i] <= '0;
        partQ[i]  <= 1'b0;
      end
    end else begin
      if (strb.markPartial) partQ[headPtr] <= 1'b1;
      if (strb.push) begin
        addrQ[tailPtr]  <= curAddr;
        valQ[tailPtr]   <= hostData;
        codeQ[tailPtr]  <= cmdCode;
        readyQ[tailPtr] <= readyAt;
        partQ[tailPtr]  <= 1'b0;
      end
    end
  end

  // target address register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (addrLoad) begin
      curAddr <= addrLoadVal;
    end else if (strb.push) begin
      curAddr <= curAddr + ADDR_W'(autoInc);
    end
  end

  // registered memory write ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vramWe     <= 1'b0;
      vramAddr   <= '0;
      vramData   <= '0;
      cramWe     <= 1'b0;
      cramAddr   <= '0;
      cramData   <= '0;
      scrollWe   <= 1'b0;
      scrollAddr <= '0;
      scrollData <= '0;
    end else begin
      vramWe   <= strb.writeHi || strb.writeLo;
      cramWe   <= strb.writeCram;
      scrollWe <= strb.writeScroll && scrollInRange;
      if (strb.writeHi) begin
        vramAddr <= headAddr;
        vramData <= headVal[DATA_W-1 -: BYTE_W];
      end else if (strb.writeLo) begin
        vramAddr <= {headAddr[ADDR_W-1:1], ~headAddr[0]};
        vramData <= headVal[BYTE_W-1:0];
      end
      if (strb.writeCram) begin
        cramAddr <= headAddr[CRAM_AW:1];
        cramData <= headVal;
      end
      if (strb.writeScroll) begin
        scrollAddr <= scrollIdx;
        scrollData <= headVal;
      end
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({vramWe, cramWe, scrollWe}) <= 1); // R3
  AST_SCROLL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    scrollWe |-> ({1'b0, scrollAddr} < SCROLL_LIM)); // R7
  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rstN)
    strb.markPartial |=> headPartial); // R5
endmodule

// File: rtl/slotWriteQueue.sv
module slotWriteQueue
  import swq_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int CYC_W        = 32,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int INC_W        = 8,
  parameter int CRAM_AW      = 6,
  parameter int SCROLL_AW    = 6,
  parameter int SCROLL_WORDS = 40,
  parameter int SLOT_WIDE    = 16,
  parameter int SLOT_NARROW  = 20,
  parameter int LAT_SLOTS    = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [DATA_W-1:0]    hostData,
  input  logic [CODE_W-1:0]    cmdCode,
  input  logic                 addrLoad,
  input  logic [ADDR_W-1:0]    addrLoadVal,
  input  logic [INC_W-1:0]     autoInc,
  output logic                 hostStall,
  input  logic                 slotStrobe,
  input  logic [CYC_W-1:0]     cycleNow,
  input  logic                 wideMode,
  output logic                 vramWe,
  output logic [ADDR_W-1:0]    vramAddr,
  output logic [BYTE_W-1:0]    vramData,
  output logic                 cramWe,
  output logic [CRAM_AW-1:0]   cramAddr,
  output logic [DATA_W-1:0]    cramData,
  output logic                 scrollWe,
  output logic [SCROLL_AW-1:0] scrollAddr,
  output logic [DATA_W-1:0]    scrollData,
  output logic                 slotUnused
);
  swq_strobe_t       strb;
  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [CYC_W-1:0]  headReady;
  logic [CODE_W-1:0] headCode;
  logic              headPartial;
  logic [ADDR_W-1:0] curAddr;
  logic              hostReq;

  assign hostReq = hostWrEn && cmdCode[0];

  swq_ctrl #(.DEPTH(DEPTH), .CYC_W(CYC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .slotStrobe(slotStrobe),
    .cycleNow(cycleNow), .headReady(headReady), .headCode(headCode),
    .headPartial(headPartial), .hostStall(hostStall), .slotUnused(slotUnused),
    .headPtr(headPtr), .tailPtr(tailPtr), .strb(strb)
  );

  swq_data #(
    .DEPTH(DEPTH), .CYC_W(CYC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INC_W(INC_W), .CRAM_AW(CRAM_AW), .SCROLL_AW(SCROLL_AW),
    .SCROLL_WORDS(SCROLL_WORDS), .SLOT_WIDE(SLOT_WIDE),
    .SLOT_NARROW(SLOT_NARROW), .LAT_SLOTS(LAT_SLOTS)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .headPtr(headPtr), .tailPtr(tailPtr),
    .hostData(hostData), .cmdCode(cmdCode), .addrLoad(addrLoad),
    .addrLoadVal(addrLoadVal), .autoInc(autoInc), .cycleNow(cycleNow),
    .wideMode(wideMode), .headReady(headReady), .headCode(headCode),
    .headPartial(headPartial), .curAddr(curAddr),
    .vramWe(vramWe), .vramAddr(vramAddr), .vramData(vramData),
    .cramWe(cramWe), .cramAddr(cramAddr), .cramData(cramData),
    .scrollWe(scrollWe), .scrollAddr(scrollAddr), .scrollData(scrollData)
  );

  AST_WRITE_ON_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (vramWe || cramWe || scrollWe) |-> $past(slotStrobe)); // R3
  AST_READ_SETUP_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !cmdCode[0] && !addrLoad) |=> $stable(curAddr)); // R8
  AST_UNUSED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !slotStrobe |=> $stable(slotUnused)); // R4
endmodule

// File: tb/slotWriteQueue_tb.sv
`timescale 1ns/1ps
module slotWriteQueue_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic        hostWrEn;
  logic [15:0] hostData;
  logic [3:0]  cmdCode;
  logic        addrLoad;
  logic [15:0] addrLoadVal;
  logic [7:0]  autoInc;
  logic        hostStall;
  logic        slotStrobe;
  logic [31:0] cycleNow;
  logic        wideMode;
  logic        vramWe, cramWe, scrollWe, slotUnused;
  logic [15:0] vramAddr, cramData, scrollData;
  logic [7:0]  vramData;
  logic [5:0]  cramAddr, scrollAddr;

  slotWriteQueue dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostData(hostData),
    .cmdCode(cmdCode), .addrLoad(addrLoad), .addrLoadVal(addrLoadVal),
    .autoInc(autoInc), .hostStall(hostStall), .slotStrobe(slotStrobe),
    .cycleNow(cycleNow), .wideMode(wideMode), .vramWe(vramWe),
    .vramAddr(vramAddr), .vramData(vramData), .cramWe(cramWe),
    .cramAddr(cramAddr), .cramData(cramData), .scrollWe(scrollWe),
    .scrollAddr(scrollAddr), .scrollData(scrollData), .slotUnused(slotUnused)
  );

  typedef struct {
    logic [15:0] a;
    logic [15:0] v;
    logic [3:0]  c;
    longint      r;
    bit          p;
  } ent_t;

  int checks = 0;
  int failures = 0;
  string phase = "";
  ent_t mq[4];
  int mCnt = 0;
  logic [15:0] mCur = '0;
  longint cyc = 0;
  int slotPh = 0;
  bit wide = 1'b1;

  bit eVWe, eCWe, eSWe, eUnused;
  logic [15:0] eVA, eCD, eSD;
  logic [7:0]  eVD;
  logic [5:0]  eCA, eSA;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL [%s] %s actual=%0h expected=%0h", phase, tag, act, exp);
    end
  endtask

  function automatic int slotLen();
    return wide ? 16 : 20;
  endfunction

  // one clock: drive at negedge, model the edge, compare after it
  task automatic step(input bit we, input logic [15:0] d, input logic [3:0] c,
                      input bit ld, input logic [15:0] lv, output bit stalled);
    bit slot, pushOk, pop;
    logic [5:0] idx;
    slot = (slotPh == slotLen() - 1);
    hostWrEn = we; hostData = d; cmdCode = c; addrLoad = ld; addrLoadVal = lv;
    slotStrobe = slot; cycleNow = 32'(cyc); wideMode = wide;
    #1;
    stalled = we && c[0] && (mCnt == 4);
    chk("R9 hostStall", 32'(hostStall), 32'(stalled));
    pushOk = we && c[0] && (mCnt < 4);
    eVWe = 0; eCWe = 0; eSWe = 0;
    if (slot) begin
      if (mCnt > 0 && cyc >= mq[0].r) begin
        eUnused = 0;
        pop = 1;
        case (mq[0].c)
          4'd1: begin
            eVWe = 1;
            if (!mq[0].p) begin
              eVA = mq[0].a; eVD = mq[0].v[15:8]; mq[0].p = 1; pop = 0;
            end else begin
              eVA = mq[0].a ^ 16'h1; eVD = mq[0].v[7:0];
            end
          end
          4'd3: begin eCWe = 1; eCA = mq[0].a[6:1]; eCD = mq[0].v; end
          4'd5: begin
            idx = mq[0].a[6:1];
            if (idx < 40) begin eSWe = 1; eSA = idx; eSD = mq[0].v; end
          end
          default: ;
        endcase
        if (pop) begin
          for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
          mCnt--;
        end
      end else begin
        eUnused = 1;
      end
    end
    if (pushOk) begin
      mq[mCnt] = '{a: mCur, v: d, c: c, r: cyc + 3 * slotLen(), p: 0};
      mCnt++;
      mCur = mCur + 16'(autoInc);
    end
    if (ld) mCur = lv;
    @(posedge clk);
    @(negedge clk);
    chk("R4 slotUnused", 32'(slotUnused), 32'(eUnused));
    chk("R2 R3 R5 vramWe", 32'(vramWe), 32'(eVWe));
    chk("R3 R6 cramWe", 32'(cramWe), 32'(eCWe));
    chk("R3 R7 scrollWe", 32'(scrollWe), 32'(eSWe));
    if (eVWe) begin
      chk("R5 R10 R11 vramAddr", 32'(vramAddr), 32'(eVA));
      chk("R5 R11 vramData", 32'(vramData), 32'(eVD));
    end
    if (eCWe) begin
      chk("R6 R10 cramAddr", 32'(cramAddr), 32'(eCA));
      chk("R6 R11 cramData", 32'(cramData), 32'(eCD));
    end
    if (eSWe) begin
      chk("R7 scrollAddr", 32'(scrollAddr), 32'(eSA));
      chk("R7 R11 scrollData", 32'(scrollData), 32'(eSD));
    end
    cyc++;
    slotPh = slot ? 0 : slotPh + 1;
  endtask

  task automatic idle(input int n);
    bit st;
    for (int i = 0; i < n; i++) step(0, 16'h0, 4'h0, 0, 16'h0, st);
  endtask

  task automatic loadAddr(input logic [15:0] a);
    bit st;
    step(0, 16'h0, 4'h0, 1, a, st);
  endtask

  task automatic pushWord(input logic [15:0] d, input logic [3:0] c);
    bit st;
    do step(1, d, c, 0, 16'h0, st); while (st);
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL [watchdog] run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit pend, st, ld;
    logic [15:0] d, lv;
    logic [3:0] c;
    logic [3:0] codes[7];
    codes = '{4'd1, 4'd3, 4'd5, 4'd0, 4'd9, 4'd1, 4'd2};
    void'($urandom(32'd20240917));
    rstN = 0; hostWrEn = 0; hostData = 0; cmdCode = 0; addrLoad = 0;
    addrLoadVal = 0; autoInc = 8'd2; slotStrobe = 0; cycleNow = 0; wideMode = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    phase = "R1";
    chk("R1 vramWe", 32'(vramWe), 0);
    chk("R1 cramWe", 32'(cramWe), 0);
    chk("R1 scrollWe", 32'(scrollWe), 0);
    chk("R1 slotUnused", 32'(slotUnused), 0);
    chk("R1 hostStall", 32'(hostStall), 0);
    eUnused = 0;

    phase = "R2 R5 wide latency";
    loadAddr(16'h0100);
    pushWord(16'hABCD, 4'd1);
    idle(120);

    phase = "R8 read setup ignored";
    step(1, 16'h1234, 4'd0, 0, 16'h0, st);
    pushWord(16'h5678, 4'd3);
    idle(80);

    phase = "R9 R11 burst full";
    loadAddr(16'h0200);
    pushWord(16'h1111, 4'd1);
    pushWord(16'h2222, 4'd3);
    pushWord(16'h3333, 4'd5);
    pushWord(16'h4444, 4'd1);
    pushWord(16'h5555, 4'd3);
    pushWord(16'h6666, 4'd1);
    idle(300);

    phase = "R12 unknown code";
    pushWord(16'h7777, 4'd9);
    pushWord(16'h8888, 4'd3);
    idle(120);

    phase = "R7 scroll range";
    loadAddr(16'h004E);
    pushWord(16'h9999, 4'd5);
    pushWord(16'hAAAA, 4'd5);
    loadAddr(16'h0060);
    pushWord(16'hBBBB, 4'd5);
    idle(150);

    phase = "R2 R6 narrow latency";
    wide = 0; slotPh = 0;
    autoInc = 8'd4;
    pushWord(16'hCCCC, 4'd3);
    pushWord(16'hDDDD, 4'd1);
    idle(200);

    phase = "R10 random mix";
    pend = 0; d = 0; c = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!pend && $urandom_range(0, 2) == 0) begin
        pend = 1;
        d = 16'($urandom);
        c = codes[$urandom_range(0, 6)];
      end
      ld = ($urandom_range(0, 24) == 0);
      lv = 16'($urandom);
      if ($urandom_range(0, 99) == 0) autoInc = 8'($urandom_range(0, 3) * 2 + $urandom_range(0, 1));
      if (i % 700 == 699) begin wide = ~wide; slotPh = 0; end
      step(pend, d, c, ld, lv, st);
      if (!st) pend = 0;
    end
    idle(200);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule